// File: doc/BRIEF.md
# Predictive Autoranging Gain Controller

This block picks the gain of an external programmable-gain amplifier that sits in front of a 16-bit bipolar converter. Only two settings exist: unity and x100. Each time a raw converter result arrives with its valid strobe, the controller decides what gain the next conversion uses. The decision depends on the present gain and on the raw result.

At unity gain the controller moves up to x100 as soon as a result falls inside a narrow band around zero. At x100 it ignores the present level. Instead it extrapolates one sample ahead in a straight line from the two newest results. If that estimate would cross either of two wide limits near full scale, it drops back to unity before the converter can clip. Because the band and the limits differ, the two states have hysteresis.

The gain that was in force for each result goes out with a one-cycle-late valid pulse. Downstream scaling logic can therefore normalise every sample with the right factor.

Top module: `gain_autorange`

## Requirements
- R1: While reset is asserted, and after its release until the first valid sample, `gain_sel` is 0 (unity) and `tag_vld` is 0. The encoding is `gain_sel` = 1 for x100 and 0 for unity.
- R2: At unity gain, a valid sample strictly greater than T_IN_LO (default −162) and strictly less than T_IN_HI (default +162) sets `gain_sel` to 1 in the cycle after the strobe. A sample equal to either bound leaves the gain at unity.
- R3: At unity gain, a valid sample outside that band keeps `gain_sel` at 0, even when the sample lies well inside the outer limits.
- R4: At x100 gain, if the estimate 2·x[n] − x[n−1] is greater than T_OUT_HI (default +32507), `gain_sel` becomes 0 in the cycle after the strobe. An estimate equal to T_OUT_HI keeps x100.
- R5: At x100 gain, if the estimate is less than T_OUT_LO (default −32508), `gain_sel` becomes 0. An estimate equal to T_OUT_LO keeps x100.
- R6: At x100 gain the decision uses the estimate only. A sample below T_OUT_HI whose estimate exceeds it forces unity. A steep sample whose estimate stays inside the limits keeps x100.
- R7: The estimate is formed without wrap-around over the full input range. x[n] = +32767 with x[n−1] = 0 forces unity. x[n] = −32768 with x[n−1] = 0 also forces unity.
- R8: Without a valid strobe, `gain_sel` and `tag_vld` do not change, whatever `smp_data` does.
- R9: One cycle after each valid strobe, `tag_vld` is 1 for one cycle. At that point `tag_gain` holds the `gain_sel` value that was in force when the strobe arrived. Back-to-back strobes give back-to-back tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Raw sample valid strobe |
| smp_data | input | 16 | Raw signed two's-complement converter result |
| gain_sel | output | 1 | Gain for the next conversion (1 = x100, 0 = unity) |
| tag_vld | output | 1 | Pulse marking a tagged sample |
| tag_gain | output | 1 | Gain that applied to the tagged sample |

## Verification
The properties assume that `smp_vld` and `smp_data` are never unknown once reset is released. They also assume the thresholds are ordered T_OUT_LO < T_IN_LO < 0 < T_IN_HI < T_OUT_HI, so the band and the limits never overlap. The stimulus uses the default thresholds and changes inputs only on the falling clock edge. It puts every boundary value exactly on a threshold, both for the raw sample and for the extrapolated estimate, and walks sample histories chosen so that each estimate lands at a known point.

// File: rtl/gar_pkg.sv
package gar_pkg;
  typedef enum logic {
    GAIN_UNITY = 1'b0,
    GAIN_X100  = 1'b1
  } gain_e;
endpackage

// File: rtl/gar_history.sv
module gar_history #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] cur,
  output logic signed [W-1:0] prev
);
  logic signed [W-1:0] prev_nxt;

  always_comb begin
    prev_nxt = prev;
    if (en) prev_nxt = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= prev_nxt;
  end
endmodule

// File: rtl/gar_predictor.sv
module gar_predictor #(
  parameter int W  = 16,
  localparam int PW = W + 2
) (
  input  logic signed [W-1:0]  cur,
  input  logic signed [W-1:0]  prev,
  output logic signed [PW-1:0] cur_ext,
  output logic signed [PW-1:0] pred
);
  logic signed [PW-1:0] prev_ext;

  always_comb begin
    cur_ext  = {{2{cur[W-1]}}, cur};
    prev_ext = {{2{prev[W-1]}}, prev};
    pred     = (cur_ext <<< 1) - prev_ext;
  end
endmodule

// File: rtl/gar_decide.sv
module gar_decide
  import gar_pkg::*;
#(
  parameter int W        = 16,
  parameter int T_IN_HI  = 162,
  parameter int T_IN_LO  = -162,
  parameter int T_OUT_HI = 32507,
  parameter int T_OUT_LO = -32508,
  localparam int PW = W + 2
) (
  input  gain_e                gain_cur,
  input  logic signed [PW-1:0] cur_ext,
  input  logic signed [PW-1:0] pred,
  output gain_e                gain_nxt
);
  localparam logic signed [PW-1:0] IN_HI  = PW'(T_IN_HI);
  localparam logic signed [PW-1:0] IN_LO  = PW'(T_IN_LO);
  localparam logic signed [PW-1:0] OUT_HI = PW'(T_OUT_HI);
  localparam logic signed [PW-1:0] OUT_LO = PW'(T_OUT_LO);

  logic in_band;
  logic out_risk;

  always_comb begin
    in_band  = (cur_ext > IN_LO) && (cur_ext < IN_HI);
    out_risk = (pred > OUT_HI) || (pred < OUT_LO);
    gain_nxt = gain_cur;
    unique case (gain_cur)
      GAIN_UNITY: if (in_band)  gain_nxt = GAIN_X100;
      GAIN_X100:  if (out_risk) gain_nxt = GAIN_UNITY;
      default:    gain_nxt = GAIN_UNITY;
    endcase
  end
endmodule

// File: rtl/gain_autorange.sv
module gain_autorange
  import gar_pkg::*;
#(
  parameter int W        = 16,
  parameter int T_IN_HI  = 162,
  parameter int T_IN_LO  = -162,
  parameter int T_OUT_HI = 32507,
  parameter int T_OUT_LO = -32508
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] smp_data,
  output logic                gain_sel,
  output logic                tag_vld,
  output logic                tag_gain
);
  localparam int PW = W + 2;

  gain_e               gain_q, gain_d;
  logic                tag_vld_q, tag_vld_d;
  logic                tag_gain_q, tag_gain_d;
  logic signed [W-1:0]  prev;
  logic signed [PW-1:0] cur_ext;
  logic signed [PW-1:0] pred;
  gain_e               gain_dec;

  gar_history #(.W(W)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (smp_vld),
    .cur  (smp_data),
    .prev (prev)
  );

  gar_predictor #(.W(W)) u_pred (
    .cur    (smp_data),
    .prev   (prev),
    .cur_ext(cur_ext),
    .pred   (pred)
  );

  gar_decide #(
    .W(W), .T_IN_HI(T_IN_HI), .T_IN_LO(T_IN_LO),
    .T_OUT_HI(T_OUT_HI), .T_OUT_LO(T_OUT_LO)
  ) u_dec (
    .gain_cur(gain_q),
    .cur_ext (cur_ext),
    .pred    (pred),
    .gain_nxt(gain_dec)
  );

  always_comb begin
    gain_d     = gain_q;
    tag_gain_d = tag_gain_q;
    tag_vld_d  = smp_vld;
    if (smp_vld) begin
      gain_d     = gain_dec;
      tag_gain_d = gain_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q     <= GAIN_UNITY;
      tag_vld_q  <= 1'b0;
      tag_gain_q <= 1'b0;
    end else begin
      gain_q     <= gain_d;
      tag_vld_q  <= tag_vld_d;
      tag_gain_q <= tag_gain_d;
    end
  end

  assign gain_sel = gain_q;
  assign tag_vld  = tag_vld_q;
  assign tag_gain = tag_gain_q;
endmodule

// File: rtl/gar_checks.sv
module gar_checks #(
  parameter int W       = 16,
  parameter int T_IN_HI = 162,
  parameter int T_IN_LO = -162
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_vld,
  input logic signed [W-1:0] smp_data,
  input logic                gain_sel,
  input logic                tag_vld,
  input logic                tag_gain
);
  localparam int PW = W + 2;
  localparam logic signed [PW-1:0] LIM_HI = PW'(T_IN_HI);
  localparam logic signed [PW-1:0] LIM_LO = PW'(T_IN_LO);

  logic signed [PW-1:0] dx;
  logic                 quiet;
  assign dx    = {{2{smp_data[W-1]}}, smp_data};
  assign quiet = (dx > LIM_LO) && (dx < LIM_HI);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_unity: assert (gain_sel == 1'b0 && tag_vld == 1'b0);
    end
  end

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !gain_sel && quiet |=> gain_sel);

  a_r3_hold_unity: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !gain_sel && !quiet |=> !gain_sel);

  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(gain_sel));

  a_r9_tag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> tag_vld);

  a_r9_tag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !tag_vld);

  a_r9_tag_value: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> tag_gain == $past(gain_sel));
endmodule

bind gain_autorange gar_checks #(
  .W(W), .T_IN_HI(T_IN_HI), .T_IN_LO(T_IN_LO)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_vld (smp_vld),
  .smp_data(smp_data),
  .gain_sel(gain_sel),
  .tag_vld (tag_vld),
  .tag_gain(tag_gain)
);

// File: tb/sim_gain_autorange.sv
module sim_gain_autorange;
  localparam int CLK_PERIOD = 10;
  localparam int IN_HI  = 162;
  localparam int IN_LO  = -162;
  localparam int OUT_HI = 32507;
  localparam int OUT_LO = -32508;

  typedef struct {
    logic  gain;
    logic  tag;
    string req;
  } exp_t;

  logic               clk;
  logic               rst_n;
  logic               smp_vld;
  logic signed [15:0] smp_data;
  logic               gain_sel;
  logic               tag_vld;
  logic               tag_gain;

  int   checks;
  int   errors;
  bit   done;
  exp_t sb[$];

  logic m_gain;
  int   m_prev;

  gain_autorange u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .gain_sel(gain_sel), .tag_vld(tag_vld), .tag_gain(tag_gain)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model from the requirements; pushes expectation, drives one strobe.
  task automatic send(input int x, input string req, input int gap);
    exp_t e;
    int   est;
    e.tag = m_gain;
    est   = 2 * x - m_prev;
    if (!m_gain) begin
      if (x > IN_LO && x < IN_HI) m_gain = 1'b1;
    end else begin
      if (est > OUT_HI || est < OUT_LO) m_gain = 1'b0;
    end
    m_prev = x;
    e.gain = m_gain;
    e.req  = req;
    sb.push_back(e);
    smp_vld  = 1'b1;
    smp_data = 16'(x);
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: compare each tag against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && tag_vld) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected tag", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(gain_sel == e.gain, e.req, int'(gain_sel), int'(e.gain));
        check(tag_gain == e.tag, "R9 tag gain", int'(tag_gain), int'(e.tag));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    m_gain = 1'b0; m_prev = 0;
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    check(gain_sel == 1'b0, "R1 gain in reset", int'(gain_sel), 0);
    check(tag_vld == 1'b0, "R1 tag in reset", int'(tag_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gain_sel == 1'b0, "R1 gain after release", int'(gain_sel), 0);
    check(tag_vld == 1'b0, "R1 tag after release", int'(tag_vld), 0);

    send(162, "R2 upper bound stays unity", 1);
    send(-162, "R2 lower bound stays unity", 0);
    send(5000, "R3 outside band stays unity", 0);
    send(161, "R2 inside band goes x100", 1);
    send(1000, "R6 steep estimate inside keeps x100", 0);
    send(1001, "R6 keeps x100", 0);
    send(16754, "R4 estimate equal to upper limit keeps x100", 0);
    send(32000, "R6 sample below limit but estimate over goes unity", 1);
    send(0, "R2 zero goes x100", 0);
    send(16254, "R4 estimate over upper limit goes unity", 0);
    send(0, "R2 zero goes x100", 0);
    send(-16254, "R5 estimate equal to lower limit keeps x100", 0);
    send(0, "R5 keeps x100", 0);
    send(-16255, "R5 estimate under lower limit goes unity", 0);
    send(-100, "R2 negative in band goes x100", 0);
    send(0, "R7 keeps x100", 0);
    send(32767, "R7 positive extreme goes unity", 0);
    send(10, "R2 goes x100", 0);
    send(0, "R7 keeps x100", 0);
    send(-32768, "R7 negative extreme goes unity", 0);
    send(-32768, "R3 extreme stays unity", 0);
    send(20, "R2 goes x100", 2);

    // R8: wiggle data with no strobe; gain must hold at x100 and no tag appears.
    for (int i = 0; i < 6; i++) begin
      smp_data = (i % 2 == 0) ? 16'sd32767 : -16'sd32768;
      @(negedge clk);
      check(gain_sel == 1'b1, "R8 gain held without strobe", int'(gain_sel), 1);
      check(tag_vld == 1'b0, "R8 no tag without strobe", int'(tag_vld), 0);
    end
    send(30, "R8 history unchanged by idle data keeps x100", 2);

    check(sb.size() == 0, "R9 all samples tagged", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule